// File: doc/BRIEF.md
# Reset and Stop-Recovery Sequencer

This block sequences the chip-wide reset of a small microcontroller. A full system reset is started by power-on, by the external active-low reset pin, or by a reset request bit that the debug controller sets. Each of these holds the core for a programmable number of slow watchdog-oscillator ticks, then for a fixed tail of system clocks. The pin and power-on paths also reset the debug domain. The debug-initiated path leaves the debug domain running and clears its own request bit.

A second, lighter path wakes the chip from the low-power STOP state. It is triggered by a watchdog time-out or by a level change on any GPIO pin that is enabled for wake-up. This recovery holds the core with its own tick count and the same clock tail. It never drives the register-file reset, so only the watchdog status kept here changes. When the time-out source is in interrupt mode and interrupts are enabled, a one-cycle wake interrupt request follows the release.

A set of mutually exclusive cause flags records the last event: power-on or debug, pin, or STOP recovery. The watchdog tick arrives as a single-cycle enable.

Top module: `rstseq_top`

## Requirements
- R1: While `extRstN` is low, `coreRst`, `regfileRst` and `dbgRst` are all high, asynchronously and for as long as the pin stays low, even after the tick count has finished.
- R2: If the pin is still low when the timed sequence ends, `coreRst` stays high through the second rising edge after the pin goes high and drops at the third (two-flop synchronizer plus one state register).
- R3: A system reset keeps `coreRst` high until the rising edge that samples the SYS_TICKS-th `wdtTick` after the start. It then stays high for TAIL_CLKS more edges and falls on the TAIL_CLKS-th edge (defaults 66 and 16).
- R4: A falling pin starts a system reset on the next rising edge. Afterwards the cause flags read {flagPor,flagExt,flagStop} = 3'b010.
- R5: A `dbgRstSet` pulse sets `dbgReqBit`. On the next edge a system reset starts and `dbgReqBit` reads 0. `dbgRst` stays low throughout, `regfileRst` is high, and the flags read 3'b100.
- R6: A STOP recovery holds `coreRst` high for STOP_TICKS ticks plus TAIL_CLKS clocks, timed as in R3. `regfileRst` and `dbgRst` stay low during it, and the flags read 3'b001 afterwards.
- R7: With `stopMode` high, a `wdtTimeout` pulse starts recovery on the next edge. `wakeIrq` is high for exactly the first cycle after release, but only if `wdtIntMode` and `intEnable` were both high at the start. `wdtTimeout` with `stopMode` low has no effect.
- R8: With `stopMode` high, a change on a `gpioIn` bit whose `gpioWakeEn` bit is 1 starts recovery on the third rising edge after the change, with no `wakeIrq`. Changes on disabled bits, or any change while `stopMode` is low, have no effect.
- R9: Exactly one cause flag is set at all times after power-on. Each event sets its own flag and clears the others.
- R10: `porIn` high asynchronously drives all three reset outputs high and sets the flags to 3'b100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| porIn | input | 1 | Power-on event, active high, asynchronous |
| extRstN | input | 1 | External reset pin, active low |
| dbgRstSet | input | 1 | Debug controller strobe that sets the reset request bit |
| wdtTick | input | 1 | One-cycle enable per slow watchdog-oscillator tick |
| wdtTimeout | input | 1 | Watchdog time-out pulse |
| wdtIntMode | input | 1 | Watchdog configured to interrupt rather than reset |
| intEnable | input | 1 | Global interrupt enable |
| stopMode | input | 1 | Chip is in STOP state |
| gpioIn | input | GPIO_W | GPIO pin levels |
| gpioWakeEn | input | GPIO_W | Per-pin wake-up enable mask |
| coreRst | output | 1 | Core held in reset |
| regfileRst | output | 1 | General reset of register file and peripherals |
| dbgRst | output | 1 | Debug-domain reset |
| dbgReqBit | output | 1 | Debug reset request bit |
| flagPor | output | 1 | Cause: power-on or debug reset |
| flagExt | output | 1 | Cause: external pin reset |
| flagStop | output | 1 | Cause: STOP recovery |
| wakeIrq | output | 1 | One-cycle wake interrupt request |

## Verification
Release timing is measured for every start source while the tick spacing is random, so an off-by-one in either the tick phase or the clock tail shows up on its own. Short pin pulses and a pin held far past the time-out separate the timed release from the pin-gated release. Random wake masks, toggled pins and STOP levels test the GPIO gating both ways. The three combinations of interrupt mode and enable show that only the time-out source in interrupt mode raises the wake request.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_SYS_SLOW, ST_SYS_FAST, ST_PIN_WAIT, ST_STP_SLOW, ST_STP_FAST
  } seqState_t;

  typedef struct packed {
    logic restart;
    logic slowEn;
    logic fastEn;
    logic selStop;
    logic setExt;
    logic setPor;
    logic setStop;
    logic armIrq;
    logic fireIrq;
    logic clrDbgReq;
  } seqCmd_t;
endpackage

// File: rtl/rstseq_dp.sv
module rstseq_dp
  import rstseq_pkg::*;
#(
  parameter int GPIO_W      = 8,
  parameter int SYS_TICKS   = 66,
  parameter int STOP_TICKS  = 66,
  parameter int TAIL_CLKS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porIn,
  input  logic              extRstN,
  input  logic              wdtTick,
  input  logic              stopMode,
  input  logic              dbgRstSet,
  input  logic [GPIO_W-1:0] gpioIn,
  input  logic [GPIO_W-1:0] gpioWakeEn,
  input  seqCmd_t           cmd,
  output logic              extSyncN,
  output logic              extFall,
  output logic              gpioEdge,
  output logic              slowDone,
  output logic              fastDone,
  output logic              dbgReqBit,
  output logic              flagPor,
  output logic              flagExt,
  output logic              flagStop,
  output logic              wakeIrq
);
  localparam int SLOW_MAX = (SYS_TICKS > STOP_TICKS) ? SYS_TICKS : STOP_TICKS;
  localparam int SLOW_W   = $clog2(SLOW_MAX + 1);
  localparam int FAST_W   = $clog2(TAIL_CLKS + 1);
  localparam logic [SLOW_W-1:0] SYS_LAST  = SLOW_W'(SYS_TICKS - 1);
  localparam logic [SLOW_W-1:0] STOP_LAST = SLOW_W'(STOP_TICKS - 1);
  localparam logic [FAST_W-1:0] FAST_LAST = FAST_W'(TAIL_CLKS - 1);

  // pin synchronizer: asynchronous assertion, synchronous release
  logic pinClr;
  logic [SYNC_STAGES-1:0] extSh;
  logic extPrev;
  assign pinClr = porIn | ~extRstN;

  always_ff @(posedge clk or posedge pinClr) begin
    if (pinClr) extSh <= '0;
    else        extSh <= {extSh[SYNC_STAGES-2:0], 1'b1};
  end
  assign extSyncN = extSh[SYNC_STAGES-1];

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) extPrev <= 1'b0;
    else       extPrev <= extSyncN;
  end
  assign extFall = extPrev & ~extSyncN;

  // GPIO synchronizer chain and change detector
  logic [GPIO_W-1:0] gpioSh [SYNC_STAGES];
  logic [GPIO_W-1:0] gpioPrev;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk or posedge porIn) begin
      if (porIn)       gpioSh[g] <= '0;
      else if (g == 0) gpioSh[g] <= gpioIn;
      else             gpioSh[g] <= gpioSh[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) gpioPrev <= '0;
    else       gpioPrev <= gpioSh[SYNC_STAGES-1];
  end
  assign gpioEdge = stopMode & (|((gpioSh[SYNC_STAGES-1] ^ gpioPrev) & gpioWakeEn));

  // slow (tick) and fast (clock) hold counters
  logic [SLOW_W-1:0] slowCnt;
  logic [FAST_W-1:0] fastCnt;
  logic [SLOW_W-1:0] slowLast;

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn)                          slowCnt <= '0;
    else if (cmd.restart || !cmd.slowEn) slowCnt <= '0;
    else if (wdtTick)                   slowCnt <= slowCnt + 1'b1;
  end

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn)                          fastCnt <= '0;
    else if (cmd.restart || !cmd.fastEn) fastCnt <= '0;
    else                                fastCnt <= fastCnt + 1'b1;
  end

  assign slowLast = cmd.selStop ? STOP_LAST : SYS_LAST;
  assign slowDone = cmd.slowEn & wdtTick & (slowCnt == slowLast);
  assign fastDone = cmd.fastEn & (fastCnt == FAST_LAST);

  // cause flags, debug request bit, wake interrupt
  logic irqArm;
  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      flagPor   <= 1'b1;
      flagExt   <= 1'b0;
      flagStop  <= 1'b0;
      dbgReqBit <= 1'b0;
      irqArm    <= 1'b0;
      wakeIrq   <= 1'b0;
    end else begin
      if (cmd.setExt || cmd.setPor || cmd.setStop) begin
        flagPor  <= cmd.setPor;
        flagExt  <= cmd.setExt;
        flagStop <= cmd.setStop;
      end
      if (cmd.clrDbgReq)  dbgReqBit <= 1'b0;
      else if (dbgRstSet) dbgReqBit <= 1'b1;
      if (cmd.restart)    irqArm <= cmd.armIrq;
      wakeIrq <= cmd.fireIrq & irqArm;
    end
  end

  assert_one_cause_R9: assert property (@(posedge clk) disable iff (porIn)
    $countones({flagPor, flagExt, flagStop}) == 1);

  assert_req_clears_R5: assert property (@(posedge clk) disable iff (porIn)
    cmd.clrDbgReq |=> !dbgReqBit);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic    clk,
  input  logic    porIn,
  input  logic    extSyncN,
  input  logic    extFall,
  input  logic    dbgReqBit,
  input  logic    stopMode,
  input  logic    wdtTimeout,
  input  logic    wdtIntMode,
  input  logic    intEnable,
  input  logic    gpioEdge,
  input  logic    slowDone,
  input  logic    fastDone,
  output seqCmd_t cmd,
  output logic    coreRst,
  output logic    regfileRst,
  output logic    dbgRst
);
  seqState_t st, stNext;
  logic dbgHold, dbgHoldNext;

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      st      <= ST_SYS_SLOW;
      dbgHold <= 1'b1;
    end else begin
      st      <= stNext;
      dbgHold <= dbgHoldNext;
    end
  end

  always_comb begin
    cmd         = '0;
    stNext      = st;
    dbgHoldNext = dbgHold;
    cmd.slowEn  = (st == ST_SYS_SLOW) || (st == ST_STP_SLOW);
    cmd.fastEn  = (st == ST_SYS_FAST) || (st == ST_STP_FAST);
    cmd.selStop = (st == ST_STP_SLOW);
    if (extFall) begin
      stNext        = ST_SYS_SLOW;
      cmd.restart   = 1'b1;
      cmd.setExt    = 1'b1;
      cmd.clrDbgReq = 1'b1;
      dbgHoldNext   = 1'b1;
    end else begin
      case (st)
        ST_RUN: begin
          if (dbgReqBit) begin
            stNext        = ST_SYS_SLOW;
            cmd.restart   = 1'b1;
            cmd.setPor    = 1'b1;
            cmd.clrDbgReq = 1'b1;
          end else if (stopMode && (wdtTimeout || gpioEdge)) begin
            stNext      = ST_STP_SLOW;
            cmd.restart = 1'b1;
            cmd.setStop = 1'b1;
            cmd.armIrq  = wdtTimeout & wdtIntMode & intEnable;
          end
        end
        ST_SYS_SLOW: if (slowDone) stNext = ST_SYS_FAST;
        ST_SYS_FAST: begin
          if (fastDone) begin
            if (extSyncN) begin
              stNext      = ST_RUN;
              dbgHoldNext = 1'b0;
            end else begin
              stNext = ST_PIN_WAIT;
            end
          end
        end
        ST_PIN_WAIT: begin
          if (extSyncN) begin
            stNext      = ST_RUN;
            dbgHoldNext = 1'b0;
          end
        end
        ST_STP_SLOW: if (slowDone) stNext = ST_STP_FAST;
        ST_STP_FAST: begin
          if (fastDone) begin
            stNext      = ST_RUN;
            cmd.fireIrq = 1'b1;
          end
        end
        default: stNext = ST_SYS_SLOW;
      endcase
    end
  end

  assign coreRst    = (st != ST_RUN) | ~extSyncN;
  assign regfileRst = (st == ST_SYS_SLOW) | (st == ST_SYS_FAST) | (st == ST_PIN_WAIT) | ~extSyncN;
  assign dbgRst     = dbgHold | ~extSyncN;

  assert_release_needs_pin_R2: assert property (@(posedge clk) disable iff (porIn)
    (st == ST_RUN && $past(st) != ST_RUN) |-> $past(extSyncN));

  assert_dbg_domain_kept_R5: assert property (@(posedge clk) disable iff (porIn)
    (st == ST_RUN && dbgReqBit && !extFall && extSyncN) |=> (coreRst && (!dbgRst || !extSyncN)));

  assert_stop_keeps_regs_R6: assert property (@(posedge clk) disable iff (porIn)
    (st == ST_RUN && !dbgReqBit && !extFall && stopMode && wdtTimeout)
      |=> (coreRst && (!regfileRst || !extSyncN)));
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int GPIO_W      = 8,
  parameter int SYS_TICKS   = 66,
  parameter int STOP_TICKS  = 66,
  parameter int TAIL_CLKS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porIn,
  input  logic              extRstN,
  input  logic              dbgRstSet,
  input  logic              wdtTick,
  input  logic              wdtTimeout,
  input  logic              wdtIntMode,
  input  logic              intEnable,
  input  logic              stopMode,
  input  logic [GPIO_W-1:0] gpioIn,
  input  logic [GPIO_W-1:0] gpioWakeEn,
  output logic              coreRst,
  output logic              regfileRst,
  output logic              dbgRst,
  output logic              dbgReqBit,
  output logic              flagPor,
  output logic              flagExt,
  output logic              flagStop,
  output logic              wakeIrq
);
  seqCmd_t cmd;
  logic extSyncN, extFall, gpioEdge, slowDone, fastDone;

  rstseq_dp #(
    .GPIO_W(GPIO_W), .SYS_TICKS(SYS_TICKS), .STOP_TICKS(STOP_TICKS),
    .TAIL_CLKS(TAIL_CLKS), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .porIn(porIn), .extRstN(extRstN), .wdtTick(wdtTick),
    .stopMode(stopMode), .dbgRstSet(dbgRstSet), .gpioIn(gpioIn),
    .gpioWakeEn(gpioWakeEn), .cmd(cmd), .extSyncN(extSyncN), .extFall(extFall),
    .gpioEdge(gpioEdge), .slowDone(slowDone), .fastDone(fastDone),
    .dbgReqBit(dbgReqBit), .flagPor(flagPor), .flagExt(flagExt),
    .flagStop(flagStop), .wakeIrq(wakeIrq)
  );

  rstseq_ctrl uCtrl (
    .clk(clk), .porIn(porIn), .extSyncN(extSyncN), .extFall(extFall),
    .dbgReqBit(dbgReqBit), .stopMode(stopMode), .wdtTimeout(wdtTimeout),
    .wdtIntMode(wdtIntMode), .intEnable(intEnable), .gpioEdge(gpioEdge),
    .slowDone(slowDone), .fastDone(fastDone), .cmd(cmd), .coreRst(coreRst),
    .regfileRst(regfileRst), .dbgRst(dbgRst)
  );

  assert_wake_on_release_R7: assert property (@(posedge clk) disable iff (porIn)
    wakeIrq |-> (!coreRst && $past(coreRst)));
endmodule

// File: tb/rstseq_top_test.sv
`timescale 1ns/1ps
module rstseq_top_test;
  localparam int GW    = 8;
  localparam int SYS_T = 66;
  localparam int STP_T = 66;
  localparam int TAIL  = 16;

  logic clk = 1'b0;
  logic porIn, extRstN, dbgRstSet, wdtTick, wdtTimeout, wdtIntMode, intEnable, stopMode;
  logic [GW-1:0] gpioIn, gpioWakeEn;
  logic coreRst, regfileRst, dbgRst, dbgReqBit, flagPor, flagExt, flagStop, wakeIrq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rstseq_top uut (
    .clk(clk), .porIn(porIn), .extRstN(extRstN), .dbgRstSet(dbgRstSet),
    .wdtTick(wdtTick), .wdtTimeout(wdtTimeout), .wdtIntMode(wdtIntMode),
    .intEnable(intEnable), .stopMode(stopMode), .gpioIn(gpioIn),
    .gpioWakeEn(gpioWakeEn), .coreRst(coreRst), .regfileRst(regfileRst),
    .dbgRst(dbgRst), .dbgReqBit(dbgReqBit), .flagPor(flagPor),
    .flagExt(flagExt), .flagStop(flagStop), .wakeIrq(wakeIrq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int flagsNow();
    return {29'd0, flagPor, flagExt, flagStop};
  endfunction

  function automatic bit wakeExpected(input logic [GW-1:0] mask, input int pin, input bit stp);
    return stp && mask[pin];
  endfunction

  // random tick spacing, driven away from the active edge
  initial begin
    int gap;
    void'($urandom(32'd4711));
    wdtTick = 1'b0;
    gap = 2;
    forever begin
      @(negedge clk);
      wdtTick = (gap == 0);
      if (gap == 0) gap = $urandom_range(1, 3);
      else gap--;
    end
  end

  // waits for nTicks sampled ticks, then checks the clock tail
  task automatic checkRelease(input int nTicks, input string req);
    int seen = 0;
    while (seen < nTicks) begin
      @(posedge clk);
      if (wdtTick) seen++;
    end
    repeat (TAIL - 1) @(posedge clk);
    @(negedge clk);
    chk(req, "coreRst one clock before release", coreRst, 1);
    @(posedge clk);
    @(negedge clk);
    chk(req, "coreRst at release", coreRst, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd99));
    porIn = 1'b1; extRstN = 1'b1; dbgRstSet = 1'b0; wdtTimeout = 1'b0;
    wdtIntMode = 1'b0; intEnable = 1'b0; stopMode = 1'b0;
    gpioIn = '0; gpioWakeEn = '0;

    // R10: power-on
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "coreRst under por", coreRst, 1);
    chk("R10", "regfileRst under por", regfileRst, 1);
    chk("R10", "dbgRst under por", dbgRst, 1);
    chk("R10", "flags after por", flagsNow(), 4);
    porIn = 1'b0;
    checkRelease(SYS_T, "R3");
    chk("R3", "dbgRst after por release", dbgRst, 0);
    chk("R9", "flags stay POR", flagsNow(), 4);

    // R3/R4: short pin pulse
    repeat (5) @(negedge clk);
    extRstN = 1'b0;
    #1;
    chk("R1", "coreRst asynchronous on pin", coreRst, 1);
    @(posedge clk);
    @(negedge clk);
    extRstN = 1'b1;
    chk("R4", "flags after pin", flagsNow(), 2);
    chk("R1", "dbgRst during pin reset", dbgRst, 1);
    checkRelease(SYS_T, "R3");
    chk("R4", "regfileRst after pin reset", regfileRst, 0);

    // R1/R2: pin held well beyond the time-out
    @(negedge clk);
    extRstN = 1'b0;
    repeat (500) @(posedge clk);
    @(negedge clk);
    chk("R1", "coreRst while pin held", coreRst, 1);
    chk("R1", "regfileRst while pin held", regfileRst, 1);
    chk("R1", "dbgRst while pin held", dbgRst, 1);
    extRstN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2", "coreRst two edges after pin rise", coreRst, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R2", "coreRst three edges after pin rise", coreRst, 0);
    chk("R4", "flags after long pin", flagsNow(), 2);

    // R5: debug-initiated reset
    repeat (3) @(negedge clk);
    dbgRstSet = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dbgRstSet = 1'b0;
    chk("R5", "request bit set", dbgReqBit, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R5", "request bit self-cleared", dbgReqBit, 0);
    chk("R5", "coreRst in debug reset", coreRst, 1);
    chk("R5", "regfileRst in debug reset", regfileRst, 1);
    chk("R5", "dbgRst untouched", dbgRst, 0);
    chk("R5", "flags after debug reset", flagsNow(), 4);
    checkRelease(SYS_T, "R5");

    // R7: watchdog time-out outside STOP is ignored
    @(negedge clk);
    wdtTimeout = 1'b1;
    @(negedge clk);
    wdtTimeout = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7", "time-out without stop ignored", coreRst, 0);

    // R6/R7: time-out wake with the three mode/enable combinations
    for (int k = 0; k < 3; k++) begin
      stopMode = 1'b1;
      wdtIntMode = (k != 1);
      intEnable = (k != 2);
      @(negedge clk);
      wdtTimeout = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wdtTimeout = 1'b0;
      chk("R6", "coreRst in stop recovery", coreRst, 1);
      chk("R6", "regfileRst kept low", regfileRst, 0);
      chk("R6", "dbgRst kept low", dbgRst, 0);
      checkRelease(STP_T, "R6");
      chk("R7", "wake request after release", wakeIrq, (k == 0) ? 1 : 0);
      @(posedge clk);
      @(negedge clk);
      chk("R7", "wake request is one cycle", wakeIrq, 0);
      chk("R6", "flags after stop recovery", flagsNow(), 1);
      stopMode = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R8: random GPIO wake trials
    wdtIntMode = 1'b1;
    intEnable = 1'b1;
    for (int t = 0; t < 12; t++) begin
      logic [GW-1:0] mask;
      int pin;
      bit stp;
      bit expWake;
      int stayed;
      mask = GW'($urandom);
      pin = $urandom_range(0, GW - 1);
      stp = (t < 3) ? 1'b1 : 1'($urandom_range(0, 1));
      if (t == 0) mask[pin] = 1'b1;
      if (t == 1) mask[pin] = 1'b0;
      expWake = wakeExpected(mask, pin, stp);
      @(negedge clk);
      gpioWakeEn = mask;
      stopMode = stp;
      repeat (4) @(negedge clk);
      gpioIn[pin] = ~gpioIn[pin];
      if (expWake) begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8", "no start before third edge", coreRst, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8", "start on third edge", coreRst, 1);
        checkRelease(STP_T, "R8");
        chk("R8", "no wake request for gpio", wakeIrq, 0);
        chk("R8", "flags after gpio wake", flagsNow(), 1);
      end else begin
        stayed = 0;
        for (int c = 0; c < 12; c++) begin
          @(negedge clk);
          if (coreRst == 1'b0) stayed++;
        end
        chk("R8", "ignored gpio change", stayed, 12);
      end
      stopMode = 1'b0;
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule